// File: doc/BRIEF.md
# Interrupt Holdoff Controller

This block turns a set of sticky interrupt-status flags into the single interrupt line seen by the host. A per-source mask selects which flags may interrupt, and a global enable gates all of them. A programmable holdoff, counted in coarse ticks, delays the line so that several events can be serviced together. The holdoff can be cut short once enough receive or transmit packets have completed. A mode bit chooses whether the holdoff starts at the first pending interrupt or when interrupts are enabled.

An optional auto-disable mode lets a status read drop the global enable, so the line stays quiet until software enables it again. Software reaches four word registers through a simple read/write strobe port. Reads are combinational, and a status read clears the status flags. The tick is a prescaled system clock, with a fast and a slow period chosen by a control bit.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: Status address 0 holds sticky flags set by one-cycle `src_set` pulses. A read of address 0 returns the flags and clears them, but a set pulse in the same cycle as the read leaves its flag set.
- R2: Low sources `src_set[7:0]` map to status bits 7:0, and high sources `src_set[11:8]` map to status bits 12:9. Status bit 8 is a summary flag that reads 1 while any high source is pending, and it can be masked and can interrupt like any other bit.
- R3: `irq` stays low while the global enable (control address 2, bit 0) is 0. It also stays low while no pending flag has its bit set in the mask register (address 1).
- R4: With auto-disable set (control bit 1), a status read clears the global enable, so `irq` stays low until a write sets the enable again. The read-back of control then shows bit 0 as 0.
- R5: With a holdoff value of 0 (address 3, bits 7:0), `irq` rises right after the clock edge that sets a pending, masked and enabled flag.
- R6: With the start-on-first bit (address 3, bit 24) set and a holdoff H > 0, `irq` rises H*D+2 edges after the edge that set the first pending flag. D is FAST_DIV clocks when address 3 bit 25 is 1 and SLOW_DIV clocks when it is 0. H ranges up to 255.
- R7: With bit 24 clear, the holdoff starts when the global enable is written to 1. `irq` rises H*D+2 edges after that write edge, even when the event arrives later within the hold.
- R8: A nonzero receive threshold T (address 3, bits 12:8) ends the hold early. `irq` rises 1 edge after the edge of the T-th `rx_done` pulse counted during the hold. A threshold of 0, or fewer than T pulses, leaves the full hold.
- R9: A nonzero transmit threshold (address 3, bits 17:13) ends the hold early in the same way using `tx_done` pulses. Whichever of the hold timer and the two counters finishes first releases the line.
- R10: After the interrupt is delivered and the status is cleared, the timer and the packet counters restart. A new event then waits the full holdoff again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_set | input | 12 | One-cycle set pulses for the status flags (low sources first) |
| rx_done | input | 1 | One-cycle pulse per received packet |
| tx_done | input | 1 | One-cycle pulse per completed transmit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading address 0 clears status) |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 holdoff |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt line to the host |

## Verification
A holdoff state that is stuck or entered too early shows on `irq` as a rise latency that differs from H*D+2 edges. A wrong packet count shows as a rise that is off by even one edge from the T-th pulse plus one. The bench therefore measures the exact edge of every rise against latencies worked out from the requirements. A global enable or sticky flag that fails to clear shows within one cycle, either in the read-back of the status and control words or as an `irq` that rises when it should stay low.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;

   typedef enum logic [1:0] {
      HS_IDLE   = 2'd0,
      HS_TIMING = 2'd1,
      HS_OPEN   = 2'd2
   } hold_state_e;

   localparam logic [1:0] ADDR_STATUS = 2'd0;
   localparam logic [1:0] ADDR_MASK   = 2'd1;
   localparam logic [1:0] ADDR_CTRL   = 2'd2;
   localparam logic [1:0] ADDR_HOLD   = 2'd3;

   // holdoff word field positions
   localparam int unsigned HOLD_LSB  = 0;
   localparam int unsigned RXTHR_LSB = 8;
   localparam int unsigned TXTHR_LSB = 13;
   localparam int unsigned FIRST_BIT = 24;
   localparam int unsigned FAST_BIT  = 25;

   localparam int unsigned HOLD_FIELD_W = 8;
   localparam int unsigned THR_FIELD_W  = 5;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned LOW_N  = 8,
   parameter int unsigned HIGH_N = 4,
   localparam int unsigned NSRC  = LOW_N + HIGH_N,
   localparam int unsigned SW    = NSRC + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_set,
   input  logic            clr,
   input  logic [SW-1:0]   mask,
   input  logic            gen,
   output logic [SW-1:0]   status,
   output logic            pending
);

   logic [NSRC-1:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (clr ? '0 : raw_q) | src_set;
   end

   assign status  = {raw_q[NSRC-1:LOW_N], |raw_q[NSRC-1:LOW_N], raw_q[LOW_N-1:0]};
   assign pending = gen && |(status & mask);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_set) |=> ((raw_q & $past(src_set)) == $past(src_set))); // R1
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && src_set == '0) |=> (raw_q == '0)); // R1

endmodule

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
   parameter int unsigned FAST_DIV = 4,
   parameter int unsigned SLOW_DIV = 25,
   localparam int unsigned PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);

   logic [PW-1:0] presc_q;
   logic [PW-1:0] lim;

   generate
      if (FAST_DIV == SLOW_DIV) begin : g_single
         logic fast_unused;
         assign fast_unused = fast;
         assign lim = PW'(SLOW_DIV - 1);
      end else begin : g_dual
         assign lim = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
      end
   endgenerate

   assign tick = run && (presc_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       presc_q <= '0;
      else if (!run)    presc_q <= '0;
      else if (tick)    presc_q <= '0;
      else              presc_q <= presc_q + 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R6

endmodule

// File: rtl/irq_sat_counter.sv
module irq_sat_counter #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         ev,
   input  logic [W-1:0] thr,
   output logic         hit
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clear)                cnt_q <= '0;
      else if (ev && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
   end

   assign hit = (thr != '0) && (cnt_q >= thr);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && ev && cnt_q == '1) |=> (cnt_q == '1)); // R8

endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl
   import irq_hold_pkg::*;
#(
   parameter int unsigned LOW_N    = 8,
   parameter int unsigned HIGH_N   = 4,
   parameter int unsigned HOLD_W   = 8,
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned FAST_DIV = 4,
   parameter int unsigned SLOW_DIV = 25,
   parameter int unsigned DATA_W   = 32,
   localparam int unsigned NSRC    = LOW_N + HIGH_N,
   localparam int unsigned SW      = NSRC + 1,
   localparam int unsigned NDIR    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_set,
   input  logic              rx_done,
   input  logic              tx_done,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);

   generate
      if (LOW_N < 1 || HIGH_N < 1)            begin : g_bad_src   $error("source counts must be >= 1");       end
      if (SW > DATA_W)                        begin : g_bad_sw    $error("status wider than data word");      end
      if (HOLD_W > HOLD_FIELD_W || HOLD_W < 1) begin : g_bad_hold $error("HOLD_W exceeds its field");         end
      if (CNT_W > THR_FIELD_W || CNT_W < 1)   begin : g_bad_cnt   $error("CNT_W exceeds its field");          end
      if (FAST_DIV < 2 || SLOW_DIV < FAST_DIV) begin : g_bad_div  $error("need 2 <= FAST_DIV <= SLOW_DIV");   end
      if (DATA_W <= FAST_BIT)                 begin : g_bad_dw    $error("DATA_W too narrow for holdoff word"); end
   endgenerate

   logic              gen_q, auto_q, first_q, fast_q;
   logic [SW-1:0]     mask_q;
   logic [HOLD_W-1:0] hold_q;
   logic [CNT_W-1:0]  thr_q [NDIR];
   hold_state_e       state_q;
   logic              fired_q;

   logic              wr_ctrl, rd_status;
   logic [SW-1:0]     status;
   logic              pending, trig, expire, timing, tick, hold_hit;
   logic [NDIR-1:0]   pkt_ev, pkt_hit;
   logic              wdata_unused;

   assign wdata_unused = ^reg_wdata;
   assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
   assign rd_status = reg_rd && (reg_addr == ADDR_STATUS);

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q   <= 1'b0;
         auto_q  <= 1'b0;
         first_q <= 1'b0;
         fast_q  <= 1'b0;
         mask_q  <= '0;
         hold_q  <= '0;
         for (int d = 0; d < NDIR; d++) thr_q[d] <= '0;
      end else begin
         if (wr_ctrl) begin
            gen_q  <= reg_wdata[0];
            auto_q <= reg_wdata[1];
         end else if (auto_q && rd_status) begin
            gen_q  <= 1'b0;
         end
         if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata[SW-1:0];
         if (reg_wr && reg_addr == ADDR_HOLD) begin
            hold_q   <= reg_wdata[HOLD_LSB +: HOLD_W];
            thr_q[0] <= reg_wdata[RXTHR_LSB +: CNT_W];
            thr_q[1] <= reg_wdata[TXTHR_LSB +: CNT_W];
            first_q  <= reg_wdata[FIRST_BIT];
            fast_q   <= reg_wdata[FAST_BIT];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_STATUS: reg_rdata[SW-1:0] = status;
         ADDR_MASK:   reg_rdata[SW-1:0] = mask_q;
         ADDR_CTRL:   reg_rdata[1:0]    = {auto_q, gen_q};
         default: begin
            reg_rdata[HOLD_LSB +: HOLD_W]  = hold_q;
            reg_rdata[RXTHR_LSB +: CNT_W]  = thr_q[0];
            reg_rdata[TXTHR_LSB +: CNT_W]  = thr_q[1];
            reg_rdata[FIRST_BIT]           = first_q;
            reg_rdata[FAST_BIT]            = fast_q;
         end
      endcase
   end

   irq_status_bank #(.LOW_N(LOW_N), .HIGH_N(HIGH_N)) u_status (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .clr(rd_status),
      .mask(mask_q), .gen(gen_q), .status(status), .pending(pending)
   );

   assign timing = (state_q == HS_TIMING);

   irq_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(timing), .fast(fast_q), .tick(tick)
   );

   irq_sat_counter #(.W(HOLD_W)) u_hold_cnt (
      .clk(clk), .rst_n(rst_n), .clear(!timing), .ev(tick),
      .thr(hold_q), .hit(hold_hit)
   );

   assign pkt_ev = {tx_done, rx_done};

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_pkt
         irq_sat_counter #(.W(CNT_W)) u_pkt_cnt (
            .clk(clk), .rst_n(rst_n), .clear(!timing), .ev(pkt_ev[d]),
            .thr(thr_q[d]), .hit(pkt_hit[d])
         );
      end
   endgenerate

   assign trig   = first_q ? pending : gen_q;
   assign expire = (hold_q == '0) || hold_hit || (|pkt_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HS_IDLE;
         fired_q <= 1'b0;
      end else begin
         unique case (state_q)
            HS_IDLE: begin
               fired_q <= 1'b0;
               if (trig) state_q <= HS_TIMING;
            end
            HS_TIMING: begin
               if (!trig)       state_q <= HS_IDLE;
               else if (expire) state_q <= HS_OPEN;
            end
            HS_OPEN: begin
               if (pending)      fired_q <= 1'b1;
               else if (fired_q) state_q <= HS_IDLE;
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   assign irq = pending && (state_q == HS_OPEN || hold_q == '0);

   AST_GEN_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> gen_q); // R3
   AST_AUTO_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_q && rd_status && !wr_ctrl) |=> !gen_q); // R4
   AST_HOLD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq) && hold_q != '0) |-> ($past(state_q) != HS_IDLE)); // R6

endmodule

// File: tb/irq_holdoff_ctrl_bench.sv
module irq_holdoff_ctrl_bench;

   localparam int FDIV = 4;
   localparam int SDIV = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] src_set = '0;
   logic        rx_done = 1'b0, tx_done = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   irq_holdoff_ctrl #(.FAST_DIV(FDIV), .SLOW_DIV(SDIV)) u_irq_holdoff_ctrl (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .rx_done(rx_done),
      .tx_done(tx_done), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [7:0]  hold;
      logic        fast;
      logic [4:0]  rxthr;
      logic [4:0]  txthr;
      logic [4:0]  nrx;
      logic [4:0]  ntx;
      logic [15:0] lat;
   } vec_t;

   // latency = edges from the status-set edge to the edge after which irq is high
   localparam vec_t VECS [10] = '{
      '{8'd0,   1'b1, 5'd0, 5'd0, 5'd0,  5'd0, 16'd0},    // R5
      '{8'd3,   1'b1, 5'd0, 5'd0, 5'd0,  5'd0, 16'd14},   // R6
      '{8'd2,   1'b0, 5'd0, 5'd0, 5'd0,  5'd0, 16'd52},   // R6 slow tick
      '{8'd255, 1'b1, 5'd0, 5'd0, 5'd0,  5'd0, 16'd1022}, // R6 longest hold
      '{8'd20,  1'b1, 5'd3, 5'd0, 5'd5,  5'd0, 16'd5},    // R8
      '{8'd20,  1'b1, 5'd0, 5'd2, 5'd0,  5'd4, 16'd4},    // R9
      '{8'd5,   1'b1, 5'd0, 5'd0, 5'd6,  5'd0, 16'd22},   // R8 zero threshold
      '{8'd4,   1'b1, 5'd8, 5'd0, 5'd3,  5'd0, 16'd18},   // R8 too few packets
      '{8'd10,  1'b1, 5'd4, 5'd2, 5'd10, 5'd1, 16'd6},    // R8 R9 mixed
      '{8'd1,   1'b1, 5'd0, 5'd0, 5'd0,  5'd0, 16'd6}     // R6
   };

   function automatic logic [31:0] hold_word(input logic [7:0] h, input logic fst,
                                             input logic [4:0] rt, input logic [4:0] tt,
                                             input logic first);
      return 32'(h) | (32'(rt) << 8) | (32'(tt) << 13) | (32'(first) << 24) | (32'(fst) << 25);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] bits);
      src_set = bits;
      @(posedge clk); @(negedge clk);
      src_set = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   // caller drives the stimulus for edge 1 before calling
   task automatic wait_irq(input int maxe, output int n);
      n = 0;
      for (int e = 1; e <= maxe && n == 0; e++) begin
         @(posedge clk); @(negedge clk);
         src_set = '0; rx_done = 1'b0; tx_done = 1'b0;
         if (irq) n = e;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R3 reset irq", 32'(irq), 32'd0);
      rd(2'd0, d); chk("R1 reset status", d, 32'h0);
      rd(2'd2, d); chk("R4 reset control", d, 32'h0);

      // table: first-mode holdoff and packet-count early release
      foreach (VECS[i]) begin
         int lat;
         lat = -1;
         wr(2'd2, 32'h0);
         rd(2'd0, d);
         wr(2'd3, hold_word(VECS[i].hold, VECS[i].fast, VECS[i].rxthr, VECS[i].txthr, 1'b1));
         wr(2'd1, 32'h1FFF);
         wr(2'd2, 32'h1);
         for (int e = 1; e <= 8000 && lat < 0; e++) begin
            src_set = (e == 1) ? 12'h001 : 12'h000;
            rx_done = (e >= 3) && (e < 3 + int'(VECS[i].nrx));
            tx_done = (e >= 3) && (e < 3 + int'(VECS[i].ntx));
            @(posedge clk); @(negedge clk);
            if (irq) lat = e - 1;
         end
         src_set = '0; rx_done = 1'b0; tx_done = 1'b0;
         chk($sformatf("R5/R6/R8/R9 row %0d latency", i), 32'(lat), 32'(VECS[i].lat));
         rd(2'd0, d);
      end
      wr(2'd2, 32'h0);

      // R1: sticky set, clear on read, set wins over clear
      pulse(12'h009);
      rd(2'd0, d); chk("R1 sticky read", d, 32'h9);
      rd(2'd0, d); chk("R1 cleared by read", d, 32'h0);
      reg_rd = 1'b1; reg_addr = 2'd0; src_set = 12'h004;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0; src_set = '0;
      rd(2'd0, d); chk("R1 set beats clear", d, 32'h4);

      // R2: summary flag and high-source mapping
      pulse(12'h200);
      rd(2'd0, d); chk("R2 summary and high bit", d, 32'h500);
      wr(2'd3, 32'h0);
      wr(2'd1, 32'h100);
      wr(2'd2, 32'h1);
      src_set = 12'h100;
      wait_irq(5, n); chk("R2 summary interrupts", 32'(n), 32'd1);
      rd(2'd0, d); chk("R2 status word", d, 32'h300);

      // R3: mask and global enable
      wr(2'd1, 32'h2);
      pulse(12'h001); idle(3);
      chk("R3 masked source no irq", 32'(irq), 32'd0);
      src_set = 12'h002;
      wait_irq(5, n); chk("R3 unmasked source irq", 32'(n), 32'd1);
      rd(2'd0, d);
      wr(2'd2, 32'h0);
      pulse(12'h002); idle(3);
      chk("R3 global enable off", 32'(irq), 32'd0);
      rd(2'd0, d);

      // R4: auto-disable
      wr(2'd1, 32'h1FFF);
      wr(2'd2, 32'h3);
      src_set = 12'h001;
      wait_irq(5, n); chk("R4 irq before read", 32'(n), 32'd1);
      rd(2'd0, d);
      rd(2'd2, d); chk("R4 enable cleared", d, 32'h2);
      pulse(12'h004); idle(3);
      chk("R4 irq blocked", 32'(irq), 32'd0);
      wr(2'd2, 32'h3);
      chk("R4 irq after re-enable", 32'(irq), 32'd1);
      rd(2'd0, d);
      wr(2'd2, 32'h0);
      rd(2'd0, d);

      // R7: holdoff timed from the enable write
      wr(2'd3, hold_word(8'd5, 1'b1, 5'd0, 5'd0, 1'b0));
      wr(2'd2, 32'h1);
      idle(9);
      src_set = 12'h001;
      wait_irq(200, n); chk("R7 timed from enable", 32'(n), 32'd13);
      rd(2'd0, d);
      wr(2'd2, 32'h0);

      // R10: restart after delivery
      wr(2'd3, hold_word(8'd3, 1'b1, 5'd0, 5'd0, 1'b1));
      wr(2'd2, 32'h1);
      src_set = 12'h001;
      wait_irq(200, n); chk("R10 first hold", 32'(n), 32'd15);
      rd(2'd0, d);
      chk("R10 irq dropped after read", 32'(irq), 32'd0);
      src_set = 12'h001;
      wait_irq(200, n); chk("R10 full hold again", 32'(n), 32'd15);
      rd(2'd0, d);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule